// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block selects which of a small set of interrupt request lines should be presented to the processor. It also keeps the in-service record that nested interrupt handling depends on. A request line is a candidate when it is pending and not masked. Candidates are ranked by a circular search that starts at a programmable base offset, so the line equal to the offset ranks highest. The best candidate raises the interrupt only when it ranks strictly above every line already in service. On the primary controller of a cascaded pair, nested mode can leave the cascade line out of the in-service ranking. Then a second request arriving through the cascade can still get through.

The block owns the in-service bit vector and the rotation offset. An acknowledge strobe marks the winning line as in service. With automatic end-of-interrupt enabled, the acknowledge instead leaves that bit clear, and it can optionally rotate the priority. A non-specific end-of-interrupt strobe retires the highest-ranked in-service line, again with an optional rotation. An initialization strobe returns the offset and the in-service record to zero. The decision is registered: the interrupt flag and the granted line index reach the outputs one clock after the inputs that produced them.

Top module: `rot_prio_resolver`

## Requirements
- R1: A line is a candidate only when its pending bit is 1 and its mask bit is 0. With no candidate, `irq_out` is 0 on the following cycle.
- R2: Candidates are ranked by rank p = (line - offset) mod N, and smaller p wins. The granted line is (p + offset) mod N.
- R3: The interrupt is raised only when the best candidate's rank is strictly smaller than the smallest rank among the in-service lines. A candidate of equal or larger rank is held back.
- R4: When the block is built as the primary (IS_PRIMARY=1) and `nested_en` is 1, in-service bit CASCADE_LINE (default 2) is left out of the in-service ranking.
- R5: `irq_out` and `grant_line` are registered. They show the decision made from the inputs and state at the previous rising edge, and `grant_line` is 0 whenever `irq_out` is 0.
- R6: An acknowledge while a candidate wins, with `aeoi_en` 0, sets the in-service bit of the granted line. An acknowledge with no winner changes neither the in-service vector nor the offset.
- R7: An acknowledge while a candidate wins, with `aeoi_en` 1, leaves the granted line's in-service bit 0. If `aeoi_rotate` is also 1, the offset becomes (granted line + 1) mod N.
- R8: A non-specific end-of-interrupt clears the in-service bit with the smallest rank. Nested mode is not applied to this ranking. With `eoi_rotate` 1, the offset becomes (that line + 1) mod N. With nothing in service, it has no effect.
- R9: `init_clr` sets the offset and the in-service vector to 0 and clears `irq_out` on the next cycle. It takes precedence over acknowledge and end-of-interrupt.
- R10: When acknowledge and end-of-interrupt are strobed in the same cycle, only the acknowledge is acted on, even if nothing wins.
- R11: After reset, `irq_out`, `grant_line`, `insvc` and `prio_offset` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_pend | input | N | Pending request per line |
| req_mask | input | N | Mask per line, 1 blocks the line |
| nested_en | input | 1 | Exclude the cascade line from in-service ranking (primary only) |
| aeoi_en | input | 1 | Automatic end-of-interrupt on acknowledge |
| aeoi_rotate | input | 1 | Rotate priority on automatic end-of-interrupt |
| ack | input | 1 | Acknowledge strobe |
| eoi | input | 1 | Non-specific end-of-interrupt strobe |
| eoi_rotate | input | 1 | Rotate priority on end-of-interrupt |
| init_clr | input | 1 | Initialization strobe |
| irq_out | output | 1 | Registered interrupt request to the processor |
| grant_line | output | $clog2(N) | Registered index of the granted line |
| insvc | output | N | In-service vector |
| prio_offset | output | $clog2(N) | Current rotation offset |

## Verification
The assertions assume that strobes are sampled only while `rst_n` is high and that mode inputs may change on any cycle. They rely on `ack` seeing the same combinational winner that the bench's model computes from the same sampled inputs. The stimulus changes every input on the falling clock edge, so each rising edge sees a settled combination. It covers simultaneous acknowledge and end-of-interrupt, initialization racing both, and offsets reached only through rotation. Each mode bit is held for several cycles and then toggled, so that transitions between modes also reach the in-service update logic.

// File: rtl/rpr_pkg.sv
package rpr_pkg;

   // Kind of update applied to the in-service record on a clock edge.
   typedef enum logic [2:0] {
      ISV_HOLD,
      ISV_INIT,
      ISV_ACK_SET,
      ISV_ACK_AUTO,
      ISV_EOI
   } isv_op_e;

   // Search implementations selectable by parameter.
   localparam int FIND_LINEAR  = 0;
   localparam int FIND_ISOLATE = 1;

endpackage

// File: rtl/rpr_prio_search.sv
module rpr_prio_search #(
   parameter int N          = 8,
   parameter int W          = $clog2(N),
   parameter int FIND_STYLE = rpr_pkg::FIND_LINEAR
) (
   input  logic [N-1:0] vec,
   input  logic [W-1:0] offset,
   output logic         hit,
   output logic [W:0]   prio,
   output logic [W-1:0] line
);

   localparam logic [W:0] NONE = (W+1)'(N);

   logic [N-1:0] rot;

   // rot[p] is the line that has rank p under the current offset
   always_comb begin
      logic [W-1:0] idx;
      idx = '0;
      for (int i = 0; i < N; i++) begin
         idx    = W'(i) + offset;
         rot[i] = vec[idx];
      end
   end

   generate
      if (FIND_STYLE == rpr_pkg::FIND_ISOLATE) begin : g_isolate
         logic [N-1:0] lowest;
         assign lowest = rot & (~rot + N'(1));
         always_comb begin
            prio = '0;
            for (int i = 0; i < N; i++) begin
               if (lowest[i]) prio = prio | (W+1)'(i);
            end
            if (rot == '0) prio = NONE;
         end
      end else begin : g_linear
         always_comb begin
            prio = NONE;
            for (int i = N - 1; i >= 0; i--) begin
               if (rot[i]) prio = (W+1)'(i);
            end
         end
      end
   endgenerate

   assign hit  = |vec;
   assign line = prio[W-1:0] + offset;

endmodule

// File: rtl/rpr_insvc_tracker.sv
module rpr_insvc_tracker #(
   parameter int N = 8,
   parameter int W = $clog2(N)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         init_clr,
   input  logic         ack_req,
   input  logic         ack_win,
   input  logic [W-1:0] ack_line,
   input  logic         aeoi_en,
   input  logic         aeoi_rotate,
   input  logic         eoi_req,
   input  logic         eoi_rotate,
   input  logic         eoi_hit,
   input  logic [W-1:0] eoi_line,
   output logic [N-1:0] insvc,
   output logic [W-1:0] offset
);
   import rpr_pkg::*;

   isv_op_e      op;
   logic [N-1:0] insvc_d;
   logic [W-1:0] offset_d;
   logic [N-1:0] ack_bit;
   logic [N-1:0] eoi_bit;

   assign ack_bit = N'(1) << ack_line;
   assign eoi_bit = N'(1) << eoi_line;

   // Precedence: init, then acknowledge, then end-of-interrupt
   always_comb begin
      if (init_clr)                 op = ISV_INIT;
      else if (ack_req && ack_win)  op = aeoi_en ? ISV_ACK_AUTO : ISV_ACK_SET;
      else if (ack_req)             op = ISV_HOLD;
      else if (eoi_req && eoi_hit)  op = ISV_EOI;
      else                          op = ISV_HOLD;
   end

   always_comb begin
      insvc_d  = insvc;
      offset_d = offset;
      unique case (op)
         ISV_INIT: begin
            insvc_d  = '0;
            offset_d = '0;
         end
         ISV_ACK_SET: insvc_d = insvc | ack_bit;
         ISV_ACK_AUTO: begin
            insvc_d = insvc & ~ack_bit;
            if (aeoi_rotate) offset_d = ack_line + W'(1);
         end
         ISV_EOI: begin
            insvc_d = insvc & ~eoi_bit;
            if (eoi_rotate) offset_d = eoi_line + W'(1);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         insvc  <= '0;
         offset <= '0;
      end else begin
         insvc  <= insvc_d;
         offset <= offset_d;
      end
   end

   AST_ACK_SETS_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_clr && ack_req && ack_win && !aeoi_en) |=> insvc[$past(ack_line)]); // R6
   AST_AUTO_LEAVES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_clr && ack_req && ack_win && aeoi_en) |=> !insvc[$past(ack_line)]); // R7
   AST_AUTO_ROTATES: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_clr && ack_req && ack_win && aeoi_en && aeoi_rotate)
         |=> offset == W'($past(ack_line) + W'(1))); // R7
   AST_EOI_ONE_BIT: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_clr && !ack_req && eoi_req && (insvc != '0))
         |=> $countones(insvc) + 1 == $countones($past(insvc))); // R8
   AST_INIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      init_clr |=> (insvc == '0) && (offset == '0)); // R9
   AST_ACK_BLOCKS_EOI: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_clr && ack_req && !ack_win && eoi_req) |=> $stable(insvc) && $stable(offset)); // R10
   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_clr && !ack_req && !eoi_req) |=> $stable(insvc) && $stable(offset)); // R6

endmodule

// File: rtl/rot_prio_resolver.sv
module rot_prio_resolver #(
   parameter int N            = 8,
   parameter int CASCADE_LINE = 2,
   parameter bit IS_PRIMARY   = 1'b1,
   parameter int FIND_STYLE   = rpr_pkg::FIND_LINEAR
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N-1:0]         req_pend,
   input  logic [N-1:0]         req_mask,
   input  logic                 nested_en,
   input  logic                 aeoi_en,
   input  logic                 aeoi_rotate,
   input  logic                 ack,
   input  logic                 eoi,
   input  logic                 eoi_rotate,
   input  logic                 init_clr,
   output logic                 irq_out,
   output logic [$clog2(N)-1:0] grant_line,
   output logic [N-1:0]         insvc,
   output logic [$clog2(N)-1:0] prio_offset
);

   localparam int W = $clog2(N);
   localparam logic [N-1:0] CASC_MASK = N'(1) << CASCADE_LINE;

   generate
      if (N < 2 || (N & (N - 1)) != 0) begin : g_bad_n
         $error("rot_prio_resolver: N must be a power of two, at least 2");
      end
      if (CASCADE_LINE < 0 || CASCADE_LINE >= N) begin : g_bad_casc
         $error("rot_prio_resolver: CASCADE_LINE out of range");
      end
   endgenerate

   logic [N-1:0] cand_vec;
   logic [N-1:0] isv_view;
   logic         req_hit, isv_hit, eoi_hit;
   logic [W:0]   req_prio, isv_prio, eoi_prio;
   logic [W-1:0] req_line, isv_line, eoi_line;
   logic         win;

   assign cand_vec = req_pend & ~req_mask;

   generate
      if (IS_PRIMARY) begin : g_primary
         assign isv_view = nested_en ? (insvc & ~CASC_MASK) : insvc;
      end else begin : g_secondary
         assign isv_view = insvc;
      end
   endgenerate

   rpr_prio_search #(.N(N), .W(W), .FIND_STYLE(FIND_STYLE)) u_req_search (
      .vec(cand_vec), .offset(prio_offset),
      .hit(req_hit), .prio(req_prio), .line(req_line));

   rpr_prio_search #(.N(N), .W(W), .FIND_STYLE(FIND_STYLE)) u_isv_search (
      .vec(isv_view), .offset(prio_offset),
      .hit(isv_hit), .prio(isv_prio), .line(isv_line));

   rpr_prio_search #(.N(N), .W(W), .FIND_STYLE(FIND_STYLE)) u_eoi_search (
      .vec(insvc), .offset(prio_offset),
      .hit(eoi_hit), .prio(eoi_prio), .line(eoi_line));

   // strict comparison: an empty request vector ranks N and never wins
   assign win = req_hit && (req_prio < isv_prio);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_out    <= 1'b0;
         grant_line <= '0;
      end else if (init_clr) begin
         irq_out    <= 1'b0;
         grant_line <= '0;
      end else begin
         irq_out    <= win;
         grant_line <= win ? req_line : '0;
      end
   end

   rpr_insvc_tracker #(.N(N), .W(W)) u_tracker (
      .clk(clk), .rst_n(rst_n), .init_clr(init_clr),
      .ack_req(ack), .ack_win(win), .ack_line(req_line),
      .aeoi_en(aeoi_en), .aeoi_rotate(aeoi_rotate),
      .eoi_req(eoi), .eoi_rotate(eoi_rotate),
      .eoi_hit(eoi_hit), .eoi_line(eoi_line),
      .insvc(insvc), .offset(prio_offset));

   AST_GRANT_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_out |-> grant_line == '0); // R5
   AST_GRANT_WAS_CAND: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> ((($past(cand_vec) >> grant_line) & N'(1)) != '0)); // R1
   AST_RAISE_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (!init_clr && req_hit && isv_hit && !(req_prio < isv_prio)) |=> !irq_out); // R3
   AST_EMPTY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cand_vec == '0) |=> !irq_out); // R1

endmodule

// File: tb/rot_prio_resolver_tb.sv
`timescale 1ns/1ps
module rot_prio_resolver_tb;
   localparam int N = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_pend = '0, req_mask = '0;
   logic       nested_en = 0, aeoi_en = 0, aeoi_rotate = 0;
   logic       ack = 0, eoi = 0, eoi_rotate = 0, init_clr = 0;
   logic       irq_out;
   logic [2:0] grant_line, prio_offset;
   logic [7:0] insvc;

   int total = 0, bad = 0;
   bit done = 0;
   string phase = "R11 reset";

   // reference state
   int m_isr = 0, m_off = 0, m_irq = 0, m_line = 0;

   always #2 clk = ~clk;

   rot_prio_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .req_pend(req_pend), .req_mask(req_mask),
      .nested_en(nested_en), .aeoi_en(aeoi_en), .aeoi_rotate(aeoi_rotate),
      .ack(ack), .eoi(eoi), .eoi_rotate(eoi_rotate), .init_clr(init_clr),
      .irq_out(irq_out), .grant_line(grant_line), .insvc(insvc),
      .prio_offset(prio_offset));

   function automatic int rank_of(int v, int off);
      for (int p = 0; p < N; p++)
         if (((v >> ((p + off) % N)) & 1) != 0) return p;
      return N;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_isr = 0; m_off = 0; m_irq = 0; m_line = 0;
      end else begin
         int cand, isv, rp, ip, ln, w, ep, el;
         cand = int'(req_pend & ~req_mask);
         isv  = nested_en ? (m_isr & ~4) : m_isr;
         rp   = rank_of(cand, m_off);
         ip   = rank_of(isv, m_off);
         w    = (rp < ip) ? 1 : 0;
         ln   = (rp + m_off) % N;
         m_irq  = init_clr ? 0 : w;
         m_line = (init_clr || !w) ? 0 : ln;
         if (init_clr) begin
            m_isr = 0; m_off = 0;
         end else if (ack) begin
            if (w != 0) begin
               if (aeoi_en) begin
                  m_isr = m_isr & ~(1 << ln);
                  if (aeoi_rotate) m_off = (ln + 1) % N;
               end else m_isr = m_isr | (1 << ln);
            end
         end else if (eoi) begin
            ep = rank_of(m_isr, m_off);
            if (ep < N) begin
               el = (ep + m_off) % N;
               m_isr = m_isr & ~(1 << el);
               if (eoi_rotate) m_off = (el + 1) % N;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         total++;
         if (int'(irq_out) != m_irq || int'(grant_line) != m_line ||
             int'(insvc) != m_isr || int'(prio_offset) != m_off) begin
            bad++;
            $display("FAIL %s: irq/line/isv/off actual %0d/%0d/%02h/%0d expected %0d/%0d/%02h/%0d",
                     phase, irq_out, grant_line, insvc, prio_offset,
                     m_irq, m_line, m_isr, m_off);
         end
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ack();
      ack = 1; step(1); ack = 0;
   endtask

   initial begin
      step(3);
      rst_n = 1;
      step(1);
      chk("R11 irq", int'(irq_out), 0);
      chk("R11 insvc", int'(insvc), 0);
      chk("R11 offset", int'(prio_offset), 0);

      phase = "R1 mask";
      req_pend = 8'h10; req_mask = 8'h10; step(2);
      chk("R1 masked", int'(irq_out), 0);
      phase = "R5 timing";
      req_mask = 8'h00; step(1);
      chk("R5 irq", int'(irq_out), 1);
      chk("R5 line", int'(grant_line), 4);

      phase = "R6 ack";
      pulse_ack();
      chk("R6 insvc", int'(insvc), 8'h10);
      phase = "R3 block";
      step(1);
      chk("R3 equal blocked", int'(irq_out), 0);
      req_pend = 8'h30; step(2);
      chk("R3 lower blocked", int'(irq_out), 0);
      req_pend = 8'h18; step(1);
      chk("R3 higher raised", int'(irq_out), 1);
      chk("R3 line", int'(grant_line), 3);

      phase = "R10 both";
      ack = 1; eoi = 1; step(1); ack = 0; eoi = 0;
      chk("R10 insvc", int'(insvc), 8'h18);

      phase = "R8 eoi";
      req_pend = 8'h00;
      eoi = 1; step(1); eoi = 0;
      chk("R8 plain", int'(insvc), 8'h10);
      eoi = 1; eoi_rotate = 1; step(1); eoi = 0; eoi_rotate = 0;
      chk("R8 rot insvc", int'(insvc), 0);
      chk("R8 rot offset", int'(prio_offset), 5);
      eoi = 1; step(1); eoi = 0;
      chk("R8 empty", int'(insvc), 0);

      phase = "R2 rotated";
      req_pend = 8'h41; step(2);
      chk("R2 line", int'(grant_line), 6);

      phase = "R9 init";
      pulse_ack();
      init_clr = 1; ack = 1; step(1); init_clr = 0; ack = 0;
      chk("R9 insvc", int'(insvc), 0);
      chk("R9 offset", int'(prio_offset), 0);
      chk("R9 irq", int'(irq_out), 0);

      phase = "R4 nested";
      req_pend = 8'h04; step(1);
      pulse_ack();
      chk("R4 insvc", int'(insvc), 8'h04);
      step(2);
      chk("R4 off blocked", int'(irq_out), 0);
      nested_en = 1; step(2);
      chk("R4 on raised", int'(irq_out), 1);
      chk("R4 line", int'(grant_line), 2);
      nested_en = 0;

      phase = "R7 auto";
      init_clr = 1; step(1); init_clr = 0;
      aeoi_en = 1; aeoi_rotate = 1; req_pend = 8'h08; step(1);
      pulse_ack();
      chk("R7 insvc", int'(insvc), 0);
      chk("R7 offset", int'(prio_offset), 4);
      aeoi_en = 0; aeoi_rotate = 0;

      phase = "R2 random";
      for (int i = 0; i < 4000; i++) begin
         req_pend   = 8'($urandom);
         req_mask   = ($urandom % 3 == 0) ? 8'($urandom) : 8'h00;
         ack        = ($urandom % 5 == 0);
         eoi        = ($urandom % 5 == 0);
         eoi_rotate = ($urandom % 2 == 0);
         init_clr   = ($urandom % 60 == 0);
         if (i % 97 == 0) begin
            nested_en   = $urandom % 2;
            aeoi_en     = $urandom % 2;
            aeoi_rotate = $urandom % 2;
         end
         step(1);
      end
      ack = 0; eoi = 0; init_clr = 0;
      step(2);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1;
         total++; bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule